// File: doc/BRIEF.md
# Base-and-Limit Address Guard with Relocation

The block sits on the path from a processor to memory and polices every access made by user code. It keeps two registers, a base and a limit, which together describe the one window of memory that the running user program may touch. A request made in kernel mode goes to memory untouched. A request made in user mode goes to memory only when its address lies inside the window. Otherwise the request is dropped and a trap pulse tells the operating system what went wrong and which address caused it.

A static select input chooses one of two ways to treat user addresses. In check-only mode an address is physical already and is compared against the window. In relocate mode the address is an offset. It is compared against the limit, and the base is then added to form the physical address. The two registers can be written only from kernel mode. A write made from user mode is discarded and raises a trap with its own cause code. Every result appears at the memory and trap outputs one clock after the request.

Top module: `reloc_guard`

## Requirements
- R1: After reset, base and limit are both 0, `mem_valid` and `trap` are low, and every user-mode request traps until kernel mode writes the registers.
- R2: A request with `cpu_user`=0 (kernel) is never checked and never relocated. One cycle later `mem_valid`=1 and `mem_addr`=`cpu_addr`.
- R3: With `reloc_en`=0, a user request (`cpu_user`=1) is legal exactly when base <= address < base + limit. The sum is formed at AW+1 bits so that a carry never wraps it. A legal request gives `mem_addr`=`cpu_addr` one cycle later.
- R4: With `reloc_en`=1, a user request is legal exactly when address < limit and address + base does not carry out of AW bits. A legal request gives `mem_addr`=`cpu_addr`+base one cycle later.
- R5: An illegal user request never raises `mem_valid`. One cycle later `trap` is high for one cycle, with `trap_cause`=0 (range fault) and `fault_addr`=`cpu_addr`.
- R6: A register write with `cfg_user`=0 loads the base when `cfg_sel`=0 and the limit when `cfg_sel`=1. The new value governs requests from the next cycle on. A request in the same cycle as the write still sees the old value.
- R7: A register write with `cfg_user`=1 changes neither register. One cycle later it gives `trap`=1, `trap_cause`=1 (privilege fault) and `fault_addr`=`cfg_wdata`.
- R8: When a range fault and a privilege fault fall in the same cycle, the range fault wins: `trap_cause`=0 and `fault_addr`=`cpu_addr`. The user write is still dropped.
- R9: `trap` is high only in the cycle after a fault. Idle cycles (`cpu_valid`=0, `cfg_we`=0) give `mem_valid`=0 and `trap`=0, and `fault_addr` keeps its last value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reloc_en | input | 1 | 0: check-only, 1: relocate user addresses |
| cpu_valid | input | 1 | Processor request present |
| cpu_addr | input | AW | Processor address |
| cpu_user | input | 1 | Mode bit of the request, 0 kernel, 1 user |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | 1 | Register select, 0 base, 1 limit |
| cfg_wdata | input | AW | Register write data |
| cfg_user | input | 1 | Mode bit of the write, 0 kernel, 1 user |
| mem_valid | output | 1 | Request forwarded to memory |
| mem_addr | output | AW | Physical address to memory |
| trap | output | 1 | One-cycle fault pulse |
| trap_cause | output | 1 | 0 range fault, 1 privilege fault |
| fault_addr | output | AW | Latched faulting address or rejected write data |

## Verification
The bench probes the window edges. It checks the first and last legal address (base and base+limit-1) and the addresses just outside them. A design with an inclusive upper bound or an off-by-one lower bound would let a neighbour's byte through. It also places the window at the top of the address space. A sum truncated to AW bits would wrap, and addresses far below the base would then pass as legal, or a relocated address would wrap into low memory. Finally, it issues writes from user mode, alone and together with range faults, and then probes the window again. A design that lets such a write through, or that reports the wrong cause when both faults occur, shows it in the next responses.

// File: rtl/reloc_pkg.sv
// Shared constants for the base-and-limit address guard.
// Assumes: one-bit register select and one-bit trap cause.
package reloc_pkg;
    localparam logic SEL_BASE  = 1'b0;
    localparam logic SEL_LIMIT = 1'b1;

    typedef enum logic {
        CAUSE_RANGE = 1'b0,
        CAUSE_PRIV  = 1'b1
    } trap_cause_e;
endpackage

// File: rtl/reloc_regs.sv
// Holds the base and limit registers. Only writes issued in kernel mode
// (wr_user = 0) update them. A user-mode write is flagged as a privilege
// fault and otherwise ignored.
// Assumes: synchronous active-low reset to base 0, limit 0.
module reloc_regs
    import reloc_pkg::*;
#(
    parameter int AW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic          wr_user,
    input  logic          wr_sel,
    input  logic [AW-1:0] wr_data,
    output logic [AW-1:0] base_o,
    output logic [AW-1:0] limit_o,
    output logic          priv_fault_o
);
    logic [AW-1:0] base_q;
    logic [AW-1:0] limit_q;
    logic          kern_wr;

    // Decode: a write is honoured only from kernel mode.
    always_comb begin
        kern_wr      = wr_en && !wr_user;
        priv_fault_o = wr_en && wr_user;
    end

    // Register update for the selected register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_q  <= '0;
            limit_q <= '0;
        end else if (kern_wr) begin
            if (wr_sel == SEL_BASE) base_q  <= wr_data;
            else                    limit_q <= wr_data;
        end
    end

    assign base_o  = base_q;
    assign limit_o = limit_q;

    // R7
    user_write_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_user) |=> ($stable(base_q) && $stable(limit_q)));

    // R6
    kernel_base_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !wr_user && wr_sel == SEL_BASE) |=> (base_q == $past(wr_data)));

    // R6
    kernel_limit_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !wr_user && wr_sel == SEL_LIMIT) |=> (limit_q == $past(wr_data)));
endmodule

// File: rtl/reloc_check.sv
// Combinational legality test and address formation for one request.
// Check-only: legal when base <= addr < base+limit, address unchanged.
// Relocate: legal when addr < limit and addr+base has no carry out, and the
// address becomes addr+base. Kernel-mode requests are always legal and are
// never relocated.
// Assumes: sums are kept at AW+1 bits so that a carry never wraps them.
module reloc_check #(
    parameter int AW = 32
) (
    input  logic [AW-1:0] addr,
    input  logic          user,
    input  logic          reloc,
    input  logic [AW-1:0] base,
    input  logic [AW-1:0] limit,
    output logic          legal_o,
    output logic [AW-1:0] phys_o
);
    localparam int SW = AW + 1;

    logic [SW-1:0] window_end;
    logic [SW-1:0] moved;
    logic          ok_check;
    logic          ok_reloc;

    // Wide sums: window end and relocated address, both with carry.
    always_comb begin
        window_end = {1'b0, base} + {1'b0, limit};
        moved      = {1'b0, base} + {1'b0, addr};
    end

    // Legality per mode; a kernel request bypasses the test.
    always_comb begin
        ok_check = (addr >= base) && ({1'b0, addr} < window_end);
        ok_reloc = (addr < limit) && !moved[SW-1];
        legal_o  = !user || (reloc ? ok_reloc : ok_check);
    end

    // Physical address: only user requests in relocate mode are shifted.
    always_comb begin
        phys_o = (user && reloc) ? moved[AW-1:0] : addr;
    end
endmodule

// File: rtl/reloc_guard.sv
// Top of the base-and-limit address guard. Checks each processor request,
// optionally relocates it and registers the result towards memory. Range
// faults and user-mode register writes give a one-cycle trap with a cause
// and a latched faulting value. A range fault takes priority over a
// privilege fault in the same cycle.
// Assumes: reloc_en is static while requests flow; one-cycle latency.
module reloc_guard
    import reloc_pkg::*;
#(
    parameter int AW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          reloc_en,
    input  logic          cpu_valid,
    input  logic [AW-1:0] cpu_addr,
    input  logic          cpu_user,
    input  logic          cfg_we,
    input  logic          cfg_sel,
    input  logic [AW-1:0] cfg_wdata,
    input  logic          cfg_user,
    output logic          mem_valid,
    output logic [AW-1:0] mem_addr,
    output logic          trap,
    output logic          trap_cause,
    output logic [AW-1:0] fault_addr
);
    logic [AW-1:0] base_w;
    logic [AW-1:0] limit_w;
    logic          priv_fault;
    logic          legal;
    logic [AW-1:0] phys;
    logic          range_fault;

    logic          mv_q;
    logic [AW-1:0] ma_q;
    logic          tr_q;
    trap_cause_e   tc_q;
    logic [AW-1:0] fa_q;

    reloc_regs #(.AW(AW)) u_regs (
        .clk          (clk),
        .rst_n        (rst_n),
        .wr_en        (cfg_we),
        .wr_user      (cfg_user),
        .wr_sel       (cfg_sel),
        .wr_data      (cfg_wdata),
        .base_o       (base_w),
        .limit_o      (limit_w),
        .priv_fault_o (priv_fault)
    );

    reloc_check #(.AW(AW)) u_chk (
        .addr    (cpu_addr),
        .user    (cpu_user),
        .reloc   (reloc_en),
        .base    (base_w),
        .limit   (limit_w),
        .legal_o (legal),
        .phys_o  (phys)
    );

    // A range fault is a valid request that failed the test.
    always_comb range_fault = cpu_valid && !legal;

    // Output stage: memory request and trap report, one cycle after input.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mv_q <= 1'b0;
            ma_q <= '0;
            tr_q <= 1'b0;
            tc_q <= CAUSE_RANGE;
            fa_q <= '0;
        end else begin
            mv_q <= cpu_valid && legal;
            if (cpu_valid && legal) ma_q <= phys;
            tr_q <= range_fault || priv_fault;
            if (range_fault) begin
                tc_q <= CAUSE_RANGE;
                fa_q <= cpu_addr;
            end else if (priv_fault) begin
                tc_q <= CAUSE_PRIV;
                fa_q <= cfg_wdata;
            end
        end
    end

    assign mem_valid  = mv_q;
    assign mem_addr   = ma_q;
    assign trap       = tr_q;
    assign trap_cause = tc_q;
    assign fault_addr = fa_q;

    // R2
    kernel_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_valid && !cpu_user) |=> (mem_valid && mem_addr == $past(cpu_addr)));

    // R1
    zero_limit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_valid && cpu_user && limit_w == '0) |=> (trap && !mem_valid));

    // R5
    trap_blocks_mem_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (trap && trap_cause == CAUSE_RANGE) |-> !mem_valid);

    // R9
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!cpu_valid && !cfg_we) |=> (!trap && !mem_valid && $stable(fault_addr)));
endmodule

// File: tb/tb_reloc_guard.sv
module tb_reloc_guard;
    localparam int AW = 32;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          reloc_en;
    logic          cpu_valid;
    logic [AW-1:0] cpu_addr;
    logic          cpu_user;
    logic          cfg_we;
    logic          cfg_sel;
    logic [AW-1:0] cfg_wdata;
    logic          cfg_user;
    logic          mem_valid;
    logic [AW-1:0] mem_addr;
    logic          trap;
    logic          trap_cause;
    logic [AW-1:0] fault_addr;

    int checks = 0;
    int errors = 0;
    bit done   = 0;

    logic [AW-1:0] m_base  = '0;
    logic [AW-1:0] m_limit = '0;
    logic [AW-1:0] m_fault = '0;

    always #2 clk = ~clk;

    reloc_guard #(.AW(AW)) dut (
        .clk(clk), .rst_n(rst_n), .reloc_en(reloc_en),
        .cpu_valid(cpu_valid), .cpu_addr(cpu_addr), .cpu_user(cpu_user),
        .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata), .cfg_user(cfg_user),
        .mem_valid(mem_valid), .mem_addr(mem_addr), .trap(trap),
        .trap_cause(trap_cause), .fault_addr(fault_addr)
    );

    function automatic logic exp_legal(input logic [AW-1:0] a, input logic u,
                                       input logic rl, input logic [AW-1:0] b,
                                       input logic [AW-1:0] l);
        logic [AW:0] top_v;
        logic [AW:0] sum_v;
        top_v = {1'b0, b} + {1'b0, l};
        sum_v = {1'b0, b} + {1'b0, a};
        if (!u) return 1'b1;
        if (rl) return (a < l) && !sum_v[AW];
        return (a >= b) && ({1'b0, a} < top_v);
    endfunction

    function automatic logic [AW-1:0] exp_phys(input logic [AW-1:0] a, input logic u,
                                               input logic rl, input logic [AW-1:0] b);
        return (u && rl) ? a + b : a;
    endfunction

    task automatic chk(input bit ok, input string tag, input string what,
                       input logic [AW-1:0] act, input logic [AW-1:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    // One cycle of stimulus, then compare the outputs with the model.
    task automatic step(input logic v, input logic [AW-1:0] a, input logic u,
                        input logic we, input logic sel, input logic [AW-1:0] wd,
                        input logic wu, input string tag);
        logic rv, wf, e_mv;
        logic [AW-1:0] e_ma;
        rv   = v && !exp_legal(a, u, reloc_en, m_base, m_limit);
        wf   = we && wu;
        e_mv = v && !rv;
        e_ma = exp_phys(a, u, reloc_en, m_base);
        if (rv)      m_fault = a;
        else if (wf) m_fault = wd;
        @(negedge clk);
        cpu_valid = v; cpu_addr = a; cpu_user = u;
        cfg_we = we; cfg_sel = sel; cfg_wdata = wd; cfg_user = wu;
        @(posedge clk);
        #1;
        cpu_valid = 1'b0; cfg_we = 1'b0;
        chk(mem_valid == e_mv, tag, "mem_valid", {31'b0, mem_valid}, {31'b0, e_mv});
        if (e_mv) chk(mem_addr == e_ma, tag, "mem_addr", mem_addr, e_ma);
        chk(trap == (rv || wf), tag, "trap", {31'b0, trap}, {31'b0, rv || wf});
        if (rv || wf) chk(trap_cause == !rv, tag, "trap_cause",
                          {31'b0, trap_cause}, {31'b0, !rv});
        chk(fault_addr == m_fault, tag, "fault_addr", fault_addr, m_fault);
        if (we && !wu) begin
            if (sel) m_limit = wd;
            else     m_base  = wd;
        end
    endtask

    task automatic req(input logic [AW-1:0] a, input logic u, input string tag);
        step(1'b1, a, u, 1'b0, 1'b0, '0, 1'b0, tag);
    endtask

    task automatic kwrite(input logic sel, input logic [AW-1:0] wd, input string tag);
        step(1'b0, '0, 1'b0, 1'b1, sel, wd, 1'b0, tag);
    endtask

    initial begin
        int unsigned seed_dummy;
        seed_dummy = $urandom(32'd20240611);
        rst_n = 1'b0; reloc_en = 1'b0; cpu_valid = 1'b0; cpu_addr = '0; cpu_user = 1'b0;
        cfg_we = 1'b0; cfg_sel = 1'b0; cfg_wdata = '0; cfg_user = 1'b0;
        repeat (3) @(posedge clk);
        #1;
        chk(!mem_valid && !trap, "R1", "reset outputs", {30'b0, mem_valid, trap}, '0);
        @(negedge clk); rst_n = 1'b1;

        // R1: zero limit after reset, every user access traps
        req(32'h0, 1'b1, "R1");
        req(32'h1234, 1'b1, "R1");
        // R9: idle cycle drops the trap
        step(1'b0, '0, 1'b0, 1'b0, 1'b0, '0, 1'b0, "R9");
        // R2: kernel passes with zero limit
        req(32'hDEAD_BEEF, 1'b0, "R2");

        // R6 / R3: window 300040..420939
        kwrite(1'b0, 32'd300040, "R6");
        kwrite(1'b1, 32'd120900, "R6");
        req(32'd300040, 1'b1, "R3");
        req(32'd420939, 1'b1, "R3");
        req(32'd420940, 1'b1, "R5");
        req(32'd300039, 1'b1, "R5");
        req(32'd5, 1'b0, "R2");
        // R6: write and request in the same cycle, request sees old base
        step(1'b1, 32'd300040, 1'b1, 1'b1, 1'b0, 32'd300041, 1'b0, "R6");
        req(32'd300040, 1'b1, "R6");
        kwrite(1'b0, 32'd300040, "R6");

        // R7: user write dropped, then window probed
        step(1'b0, '0, 1'b0, 1'b1, 1'b1, 32'hFFFF_FFFF, 1'b1, "R7");
        req(32'd420940, 1'b1, "R7");
        req(32'd420939, 1'b1, "R7");
        // R8: both faults together
        step(1'b1, 32'd7, 1'b1, 1'b1, 1'b0, 32'd0, 1'b1, "R8");
        req(32'd300040, 1'b1, "R8");
        step(1'b0, '0, 1'b0, 1'b0, 1'b0, '0, 1'b0, "R9");

        // R3: window at the top of the address space
        kwrite(1'b0, 32'hFFFF_FF00, "R3");
        kwrite(1'b1, 32'h0000_0200, "R3");
        req(32'hFFFF_FFFF, 1'b1, "R3");
        req(32'h0000_0050, 1'b1, "R3");
        req(32'hFFFF_FEFF, 1'b1, "R3");

        // R4: relocate mode
        @(negedge clk); reloc_en = 1'b1;
        req(32'h0000_00FF, 1'b1, "R4");
        req(32'h0000_01FF, 1'b1, "R4");
        kwrite(1'b0, 32'd14000, "R4");
        kwrite(1'b1, 32'd1000, "R4");
        req(32'd346, 1'b1, "R4");
        req(32'd0, 1'b1, "R4");
        req(32'd999, 1'b1, "R4");
        req(32'd1000, 1'b1, "R4");
        req(32'd346, 1'b0, "R2");

        // Random mix
        for (int i = 0; i < 600; i++) begin
            logic v, u, we, sel, wu;
            logic [AW-1:0] a, wd;
            if (i % 150 == 0) begin
                @(negedge clk); reloc_en = $urandom_range(0, 1);
            end
            v   = ($urandom_range(0, 7) != 0);
            u   = ($urandom_range(0, 3) != 0);
            we  = ($urandom_range(0, 7) == 0);
            sel = $urandom_range(0, 1);
            wu  = $urandom_range(0, 1);
            wd  = sel ? 32'($urandom_range(0, 4096))
                      : (($urandom_range(0, 3) == 0) ? $urandom : 32'($urandom_range(0, 65535)));
            if (reloc_en) a = 32'($urandom_range(0, 32'(m_limit) + 16));
            else          a = m_base + 32'($urandom_range(0, 32'(m_limit) + 16)) - 32'd8;
            step(v, a, u, we, sel, wd, wu, "R3R4R5R7");
        end

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule